// File: doc/BRIEF.md
# Stack Region Access Filter Router

This block sits beside a core's load/store unit and steers every data memory access either to a small stack cache or to the regular L1 data cache. Only one address space may use the stack cache at a time: software programs the identifier of that address space, and the block compares it on every cycle against the page-table base value the core is currently running with. Any change to the programmed identifier raises a one-cycle flush request toward the stack cache, so no line from a previous address space survives.

For the selected address space, the block keeps one origin per privilege level, user and kernel. Each origin is the highest frame-pointer value observed at that level since the last identifier change. An access is a stack access when its address falls between the current stack pointer and the origin of the current privilege level. Such accesses take the stack-cache path, and all other accesses take the L1 path. The decision is combinational from the registered state, so an access is classified in the cycle it is presented.

Top module: `stack_route_filter`

## Requirements
- R1: After reset the selected identifier equals the RESET_ID parameter, both origins are zero and the flush output is low.
- R2: A configuration write whose data differs from the held identifier loads it and drives `flush_pulse` high for exactly the next cycle; a write of the value already held produces no flush.
- R3: When `cur_id` differs from the selected identifier, every valid access goes to the L1 path.
- R4: With matching identifiers and privilege 0 or 3, an access goes to the stack path exactly when `cur_sp <= acc_addr <= origin`, compared unsigned and inclusive at both ends; otherwise it goes to L1.
- R5: Each origin equals the largest frame-pointer sample accepted for its level; a smaller sample leaves it unchanged.
- R6: A frame-pointer sample at privilege 3 can update only the user origin, at privilege 0 only the kernel origin, and at privilege 1 or 2 neither.
- R7: A frame-pointer sample is ignored when `cur_id` differs from the selected identifier.
- R8: A change of the selected identifier clears both origins to zero at the same clock edge that loads the new value.
- R9: An access at privilege 1 or 2 always goes to the L1 path.
- R10: While `acc_valid` is high exactly one of `route_stack` and `route_l1` is high, in the same cycle; while it is low both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe for the selected identifier |
| cfg_wr_data | input | ID_W | New selected identifier |
| cur_id | input | ID_W | Page-table base value of the running context |
| cur_priv | input | 2 | Current privilege level (0 kernel, 3 user) |
| cur_sp | input | AW | Current stack pointer (top of stack) |
| fp_valid | input | 1 | Frame-pointer sample strobe |
| fp_value | input | AW | Frame-pointer sample |
| acc_valid | input | 1 | Data access present |
| acc_addr | input | AW | Data access address |
| route_stack | output | 1 | Access steered to the stack cache |
| route_l1 | output | 1 | Access steered to the L1 data cache |
| flush_pulse | output | 1 | One-cycle flush request to the stack cache |

## Verification
The assertions watch on every cycle that the two route outputs are exclusive and track `acc_valid`, that a stack route never occurs with a mismatched identifier or a middle privilege, that origins never fall except on a clear, that a clear lands as zero, that the wrong privilege never moves an origin, and that the flush pulse coincides with a change of the held identifier. Only the bench scenarios show that the origin values are the true maxima of the accepted samples, that mismatched samples are dropped, and that the window edges are inclusive: it sweeps every address of a narrow configuration against several stack pointers at each privilege level and compares against a model of the origins kept in the bench.

// File: rtl/stkrt_pkg.sv
package stkrt_pkg;
   localparam logic [1:0] PRIV_KERN = 2'd0;
   localparam logic [1:0] PRIV_USER = 2'd3;
   localparam int unsigned N_LEVELS = 2;
endpackage

// File: rtl/stkrt_sel_reg.sv
module stkrt_sel_reg #(
   parameter int unsigned ID_W = 20,
   parameter logic [ID_W-1:0] RESET_ID = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [ID_W-1:0] wr_data,
   output logic [ID_W-1:0] sel_o,
   output logic            change_o,
   output logic            flush_o
);
   logic [ID_W-1:0] sel_q;
   logic            flush_q;

   assign change_o = wr_en && (wr_data != sel_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q   <= RESET_ID;
         flush_q <= 1'b0;
      end else begin
         flush_q <= change_o;
         if (change_o) sel_q <= wr_data;
      end
   end

   assign sel_o   = sel_q;
   assign flush_o = flush_q;

   assert_flush_on_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sel_q) |-> flush_q);
   assert_flush_only_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
      flush_q |-> !$stable(sel_q));
endmodule

// File: rtl/stkrt_origin.sv
module stkrt_origin #(
   parameter int unsigned AW = 32,
   parameter logic [1:0]  LEVEL = 2'd3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          sample_i,
   input  logic [1:0]    priv_i,
   input  logic [AW-1:0] fp_i,
   output logic [AW-1:0] max_o
);
   logic [AW-1:0] max_q;
   logic          take;

   assign take = sample_i && (priv_i == LEVEL) && (fp_i > max_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      max_q <= '0;
      else if (clr_i)  max_q <= '0;
      else if (take)   max_q <= fp_i;
   end

   assign max_o = max_q;

   assert_origin_monotonic_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> max_q >= $past(max_q));
   assert_origin_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> max_q == '0);
   assert_origin_level_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && priv_i != LEVEL) |=> max_q == $past(max_q));
   assert_origin_needs_sample_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !sample_i) |=> $stable(max_q));
endmodule

// File: rtl/stkrt_window.sv
module stkrt_window #(
   parameter int unsigned AW = 32
) (
   input  logic [AW-1:0] addr_i,
   input  logic [AW-1:0] lo_i,
   input  logic [AW-1:0] hi_i,
   output logic          hit_o
);
   assign hit_o = (addr_i >= lo_i) && (addr_i <= hi_i);
endmodule

// File: rtl/stack_route_filter.sv
module stack_route_filter
   import stkrt_pkg::*;
#(
   parameter int unsigned AW = 32,
   parameter int unsigned ID_W = 20,
   parameter logic [ID_W-1:0] RESET_ID = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_wr_en,
   input  logic [ID_W-1:0] cfg_wr_data,
   input  logic [ID_W-1:0] cur_id,
   input  logic [1:0]      cur_priv,
   input  logic [AW-1:0]   cur_sp,
   input  logic            fp_valid,
   input  logic [AW-1:0]   fp_value,
   input  logic            acc_valid,
   input  logic [AW-1:0]   acc_addr,
   output logic            route_stack,
   output logic            route_l1,
   output logic            flush_pulse
);
   if (AW < 2 || AW > 64) begin : g_bad_aw
      $error("stack_route_filter: AW out of range");
   end
   if (ID_W < 1 || ID_W > 64) begin : g_bad_idw
      $error("stack_route_filter: ID_W out of range");
   end

   logic [ID_W-1:0] sel_id;
   logic            sel_change;
   logic            id_match;
   logic [AW-1:0]   origin [N_LEVELS];
   logic [AW-1:0]   cur_origin;
   logic            priv_ok;
   logic            in_win;

   stkrt_sel_reg #(.ID_W(ID_W), .RESET_ID(RESET_ID)) u_sel (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
      .sel_o(sel_id), .change_o(sel_change), .flush_o(flush_pulse)
   );

   assign id_match = (cur_id == sel_id);

   for (genvar g = 0; g < N_LEVELS; g++) begin : g_lvl
      localparam logic [1:0] LVL = (g == 0) ? PRIV_KERN : PRIV_USER;
      stkrt_origin #(.AW(AW), .LEVEL(LVL)) u_org (
         .clk(clk), .rst_n(rst_n), .clr_i(sel_change),
         .sample_i(fp_valid && id_match), .priv_i(cur_priv),
         .fp_i(fp_value), .max_o(origin[g])
      );
   end

   always_comb begin
      priv_ok    = 1'b1;
      cur_origin = '0;
      unique case (cur_priv)
         PRIV_KERN: cur_origin = origin[0];
         PRIV_USER: cur_origin = origin[1];
         default:   priv_ok    = 1'b0;
      endcase
   end

   stkrt_window #(.AW(AW)) u_win (
      .addr_i(acc_addr), .lo_i(cur_sp), .hi_i(cur_origin), .hit_o(in_win)
   );

   assign route_stack = acc_valid && id_match && priv_ok && in_win;
   assign route_l1    = acc_valid && !route_stack;

   assert_route_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |-> (route_stack ^ route_l1));
   assert_route_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> !(route_stack || route_l1));
   assert_stack_needs_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
      route_stack |-> (cur_id == u_sel.sel_o));
   assert_mid_priv_l1_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && (cur_priv == 2'd1 || cur_priv == 2'd2)) |-> route_l1);
   assert_stack_above_sp_R4: assert property (@(posedge clk) disable iff (!rst_n)
      route_stack |-> (acc_addr >= cur_sp));
endmodule

// File: tb/sim_stack_route_filter.sv
module sim_stack_route_filter;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 8;
   localparam int ID_W = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_wr_en = 1'b0;
   logic [ID_W-1:0] cfg_wr_data = '0;
   logic [ID_W-1:0] cur_id = '0;
   logic [1:0] cur_priv = 2'd3;
   logic [AW-1:0] cur_sp = '0;
   logic fp_valid = 1'b0;
   logic [AW-1:0] fp_value = '0;
   logic acc_valid = 1'b0;
   logic [AW-1:0] acc_addr = '0;
   logic route_stack, route_l1, flush_pulse;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   logic [ID_W-1:0] m_sel;
   logic [AW-1:0] m_user, m_kern;

   stack_route_filter #(.AW(AW), .ID_W(ID_W), .RESET_ID('0)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
      .cur_id(cur_id), .cur_priv(cur_priv), .cur_sp(cur_sp),
      .fp_valid(fp_valid), .fp_value(fp_value),
      .acc_valid(acc_valid), .acc_addr(acc_addr),
      .route_stack(route_stack), .route_l1(route_l1), .flush_pulse(flush_pulse)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic cfg_write(input logic [ID_W-1:0] v);
      cfg_wr_en = 1'b1; cfg_wr_data = v;
      tick();
      cfg_wr_en = 1'b0;
      if (v != m_sel) begin m_sel = v; m_user = '0; m_kern = '0; end
   endtask

   task automatic fp_sample(input logic [1:0] p, input logic [AW-1:0] v);
      cur_priv = p; fp_valid = 1'b1; fp_value = v;
      tick();
      fp_valid = 1'b0;
      if (cur_id == m_sel) begin
         if (p == 2'd3 && v > m_user) m_user = v;
         if (p == 2'd0 && v > m_kern) m_kern = v;
      end
   endtask

   // full address sweep, compared with the bench model of R3, R4, R9, R10
   task automatic sweep(input logic [1:0] p, input logic [AW-1:0] sp, input string req);
      cur_priv = p; cur_sp = sp; acc_valid = 1'b1;
      for (int a = 0; a < 256; a++) begin
         logic exp_s;
         logic [AW-1:0] org;
         acc_addr = a[AW-1:0];
         org = (p == 2'd3) ? m_user : m_kern;
         exp_s = (cur_id == m_sel) && (p == 2'd3 || p == 2'd0) &&
                 (acc_addr >= sp) && (acc_addr <= org);
         #1;
         chk(req, route_stack, exp_s);
         chk("R10", route_l1, !exp_s);
      end
      acc_valid = 1'b0;
      #1;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      m_sel = '0; m_user = '0; m_kern = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1", flush_pulse, 0);
      chk("R10", route_stack | route_l1, 0);
      cur_id = 4'd0; cur_priv = 2'd3; cur_sp = 8'd0;
      acc_valid = 1'b1; acc_addr = 8'd0; #1;
      chk("R1", route_stack, 1);
      acc_addr = 8'd1; #1;
      chk("R1", route_stack, 0);
      cur_priv = 2'd0; #1;
      chk("R1", route_stack, 0);
      acc_valid = 1'b0;

      // R2: flush on change, none on same-value write
      cfg_write(4'd5);
      chk("R2", flush_pulse, 1);
      tick();
      chk("R2", flush_pulse, 0);
      cfg_write(4'd5);
      chk("R2", flush_pulse, 0);

      // R5, R6, R7: build origins
      cur_id = 4'd5;
      fp_sample(2'd3, 8'h80);
      fp_sample(2'd3, 8'h40);
      fp_sample(2'd0, 8'h30);
      fp_sample(2'd0, 8'h20);
      fp_sample(2'd1, 8'hF0);
      fp_sample(2'd2, 8'hF8);
      cur_id = 4'd6;
      fp_sample(2'd3, 8'hFF);
      fp_sample(2'd0, 8'hFF);
      cur_id = 4'd5;

      for (int p = 0; p < 4; p++) begin
         sweep(p[1:0], 8'h00, "R5");
         sweep(p[1:0], 8'h20, "R4");
         sweep(p[1:0], 8'h80, "R6");
         sweep(p[1:0], 8'h90, "R9");
      end
      cur_id = 4'd6;
      for (int p = 0; p < 4; p++) sweep(p[1:0], 8'h00, "R3");
      cur_id = 4'd5;

      // R7: mismatched samples left origins unchanged (user top still 0x80)
      cur_priv = 2'd3; cur_sp = 8'h00; acc_valid = 1'b1; acc_addr = 8'h81; #1;
      chk("R7", route_stack, 0);
      acc_addr = 8'h80; #1;
      chk("R5", route_stack, 1);
      acc_valid = 1'b0; #1;
      chk("R10", route_stack | route_l1, 0);

      // R8: identifier change clears both origins
      cfg_write(4'd9);
      chk("R2", flush_pulse, 1);
      cur_id = 4'd9;
      sweep(2'd3, 8'h00, "R8");
      sweep(2'd0, 8'h00, "R8");
      fp_sample(2'd3, 8'h10);
      sweep(2'd3, 8'h05, "R5");
      sweep(2'd0, 8'h00, "R6");

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule